// File: doc/BRIEF.md
# Register Rename Status Table

This block is the architectural register file of a dynamically scheduled core, widened so that every register also holds a producer tag. A tag of zero means the register holds its final value; a nonzero tag names the reservation station that will eventually produce the value. When an instruction dispatches, its source operands are looked up through the read ports. Each lookup returns a ready value with tag zero, or the nonzero tag of the pending producer that the station must then wait for. The same instruction's destination register is retagged through the rename port with the tag of its own station.

The table snoops the shared result bus. Any register whose tag equals the broadcast tag takes the broadcast value and drops its tag to zero. Registers holding any other tag keep their state. A later rename of the same register replaces the older tag, so only the newest producer can ever write the register back. This removes write-after-write hazards without stalling dispatch. Copying ready values into the stations at dispatch removes write-after-read hazards.

Lookups are combinational and see the table as it stood before the current cycle's rename. A lookup can also take the value straight off the bus in the cycle that value is broadcast. Reset is asserted asynchronously, released synchronously through a two-stage synchronizer, and loads every register with a configurable value and tag zero.

Top module: `rename_table`

## Requirements
- R1: After reset every register reads tag 0 and value INIT_VAL (default 5).
- R2: A rename write (rn_en high) of register i with tag t makes reads of i return tag t from the next cycle.
- R3: A second rename of the same register replaces the older tag; a later broadcast of the older tag leaves that register pending on the newer tag.
- R4: A broadcast (bus_valid high, bus_tag nonzero) whose tag equals a register's tag writes bus_val into the register and clears its tag to 0 from the next cycle.
- R5: Registers whose tag differs from bus_tag, or any register while bus_valid is low or bus_tag is 0, keep both value and tag.
- R6: One broadcast updates every register whose tag matches it, not only the first.
- R7: When a rename write and a matching broadcast hit the same register in one cycle, the register ends with the rename's tag.
- R8: A lookup of a register whose tag matches the broadcast in the same cycle returns tag 0 and bus_val.
- R9: A lookup in the same cycle as a rename of that register returns the state from before the rename.
- R10: A lookup of a pending register (nonzero tag, no matching broadcast) returns value 0.
- R11: The read ports are independent; both may look up any register, including the same one, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_idx | input | NUM_RD x AW | Register index for each lookup port |
| rd_val | output | NUM_RD x DATA_W | Value returned per port (0 while pending) |
| rd_tag | output | NUM_RD x TAG_W | Producer tag per port, 0 when the value is ready |
| rn_en | input | 1 | Rename write enable |
| rn_idx | input | AW | Destination register being renamed |
| rn_tag | input | TAG_W | Nonzero tag of the dispatching station |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | TAG_W | Tag of the broadcasting station |
| bus_val | input | DATA_W | Broadcast result value |

## Verification
The bench targets three collisions: a rename meeting a matching broadcast on the same register, a stale producer broadcasting after its register was retagged, and a lookup meeting a broadcast of its register's tag. Getting these wrong would, in turn, clear a live tag, overwrite a register with an older result, or send a dispatching station to wait for a tag that has already passed. It also checks that a lookup made in the same cycle as a rename returns the pre-rename state. Without that, an instruction that reads and writes the same register would wait on its own tag. Broadcasts with tag 0 and repeated tags across several registers are exercised as well. The stimulus biases broadcast tags toward tags that are actually pending.

// File: rtl/rt_pkg.sv
package rt_pkg;
  // Source of a lookup result
  typedef enum logic [1:0] {
    SRC_VALUE  = 2'd0,
    SRC_TAG    = 2'd1,
    SRC_BYPASS = 2'd2,
    SRC_NONE   = 2'd3
  } rd_src_e;

  // Tag value meaning "no producer pending"
  localparam int unsigned NO_TAG = 0;
endpackage

// File: rtl/rt_entry.sv
module rt_entry #(
  parameter int unsigned       DATA_W   = 16,
  parameter int unsigned       TAG_W    = 4,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rn_hit,
  input  logic [TAG_W-1:0]  rn_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  output logic [TAG_W-1:0]  q,
  output logic [DATA_W-1:0] v
);
  logic              bus_match;
  logic              q_en, v_en;
  logic [TAG_W-1:0]  q_nxt;
  logic [DATA_W-1:0] v_nxt;

  always_comb begin
    bus_match = bus_valid && (bus_tag != TAG_W'(rt_pkg::NO_TAG)) && (q == bus_tag);
    q_en  = rn_hit || bus_match;
    v_en  = bus_match;
    // rename has priority over the clearing broadcast
    q_nxt = rn_hit ? rn_tag : TAG_W'(rt_pkg::NO_TAG);
    v_nxt = bus_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= TAG_W'(rt_pkg::NO_TAG);
      v <= INIT_VAL;
    end else begin
      if (q_en) q <= q_nxt;
      if (v_en) v <= v_nxt;
    end
  end

  p_rename_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rn_hit |=> (q == $past(rn_tag)));

  p_bus_writeback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_tag != '0 && q == bus_tag && !rn_hit) |=> (q == '0 && v == $past(bus_val)));

  p_hold_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rn_hit && !(bus_valid && bus_tag != '0 && q == bus_tag)) |=> ($stable(q) && $stable(v)));

  p_stale_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && q != bus_tag && !rn_hit) |=> $stable(v));
endmodule

// File: rtl/rt_read_port.sv
module rt_read_port
  import rt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned AW       = 3
) (
  input  logic [AW-1:0]                    idx,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   q_all,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  v_all,
  input  logic                             bus_valid,
  input  logic [TAG_W-1:0]                 bus_tag,
  input  logic [DATA_W-1:0]                bus_val,
  output logic [DATA_W-1:0]                val,
  output logic [TAG_W-1:0]                 tag
);
  logic [TAG_W-1:0]  q_sel;
  logic [DATA_W-1:0] v_sel;
  logic              in_range;
  rd_src_e           src;

  always_comb begin
    in_range = ({1'b0, idx} < (AW+1)'(NUM_REGS));
    q_sel    = in_range ? q_all[idx] : TAG_W'(NO_TAG);
    v_sel    = in_range ? v_all[idx] : '0;
    if (!in_range)
      src = SRC_NONE;
    else if (q_sel == TAG_W'(NO_TAG))
      src = SRC_VALUE;
    else if (bus_valid && bus_tag == q_sel)
      src = SRC_BYPASS;
    else
      src = SRC_TAG;

    unique case (src)
      SRC_VALUE:  begin val = v_sel;   tag = TAG_W'(NO_TAG); end
      SRC_BYPASS: begin val = bus_val; tag = TAG_W'(NO_TAG); end
      SRC_TAG:    begin val = '0;      tag = q_sel;          end
      default:    begin val = '0;      tag = TAG_W'(NO_TAG); end
    endcase
  end
endmodule

// File: rtl/rename_table.sv
module rename_table #(
  parameter int unsigned       NUM_REGS = 8,
  parameter int unsigned       DATA_W   = 16,
  parameter int unsigned       TAG_W    = 4,
  parameter int unsigned       NUM_RD   = 2,
  parameter logic [DATA_W-1:0] INIT_VAL = DATA_W'(5),
  localparam int unsigned      AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_RD-1:0][AW-1:0]      rd_idx,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_val,
  output logic [NUM_RD-1:0][TAG_W-1:0]   rd_tag,
  input  logic                           rn_en,
  input  logic [AW-1:0]                  rn_idx,
  input  logic [TAG_W-1:0]               rn_tag,
  input  logic                           bus_valid,
  input  logic [TAG_W-1:0]               bus_tag,
  input  logic [DATA_W-1:0]              bus_val
);
  logic [1:0]                       rst_sync;
  logic                             rst_int_n;
  logic [NUM_REGS-1:0]              rn_hit;
  logic [NUM_REGS-1:0][TAG_W-1:0]   q_all;
  logic [NUM_REGS-1:0][DATA_W-1:0]  v_all;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign rn_hit[i] = rn_en && (rn_idx == AW'(i));
    rt_entry #(
      .DATA_W  (DATA_W),
      .TAG_W   (TAG_W),
      .INIT_VAL(INIT_VAL)
    ) i_entry (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .rn_hit   (rn_hit[i]),
      .rn_tag   (rn_tag),
      .bus_valid(bus_valid),
      .bus_tag  (bus_tag),
      .bus_val  (bus_val),
      .q        (q_all[i]),
      .v        (v_all[i])
    );
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rt_read_port #(
      .NUM_REGS(NUM_REGS),
      .DATA_W  (DATA_W),
      .TAG_W   (TAG_W),
      .AW      (AW)
    ) i_port (
      .idx      (rd_idx[p]),
      .q_all    (q_all),
      .v_all    (v_all),
      .bus_valid(bus_valid),
      .bus_tag  (bus_tag),
      .bus_val  (bus_val),
      .val      (rd_val[p]),
      .tag      (rd_tag[p])
    );
  end

  p_single_rename_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(rn_hit));

  p_rename_wins_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rn_en && bus_valid && bus_tag != '0 && q_all[rn_idx] == bus_tag)
      |=> (q_all[$past(rn_idx)] == $past(rn_tag)));
endmodule

// File: tb/test_rename_table.sv
module test_rename_table;
  localparam int CLK_P = 10;
  localparam int NR = 8;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int AW = 3;
  localparam logic [DW-1:0] IV = 16'd5;

  logic clk = 0;
  logic rst_n;
  logic [1:0][AW-1:0] rd_idx;
  logic [1:0][DW-1:0] rd_val;
  logic [1:0][TW-1:0] rd_tag;
  logic rn_en;
  logic [AW-1:0] rn_idx;
  logic [TW-1:0] rn_tag;
  logic bus_valid;
  logic [TW-1:0] bus_tag;
  logic [DW-1:0] bus_val;

  logic [TW-1:0] mq [NR];
  logic [DW-1:0] mv [NR];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rename_table i_rename_table (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_val(rd_val), .rd_tag(rd_tag),
    .rn_en(rn_en), .rn_idx(rn_idx), .rn_tag(rn_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val));

  function automatic logic [TW-1:0] exp_tag(input int i);
    if (mq[i] == 0) return 0;
    if (bus_valid && bus_tag == mq[i]) return 0;
    return mq[i];
  endfunction

  function automatic logic [DW-1:0] exp_val(input int i);
    if (mq[i] == 0) return mv[i];
    if (bus_valid && bus_tag == mq[i]) return bus_val;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_update();
    for (int i = 0; i < NR; i++) begin
      bit bm = bus_valid && bus_tag != 0 && mq[i] == bus_tag;
      if (rn_en && rn_idx == AW'(i)) mq[i] = rn_tag;
      else if (bm) mq[i] = 0;
      if (bm) mv[i] = bus_val;
    end
  endtask

  // drive one cycle, check both lookups, advance
  task automatic cyc(input string req, input bit en, input int ri, input int rt,
                     input bit bv, input int bt, input int bval, input int ra, input int rb);
    rn_en = en; rn_idx = AW'(ri); rn_tag = TW'(rt);
    bus_valid = bv; bus_tag = TW'(bt); bus_val = DW'(bval);
    rd_idx[0] = AW'(ra); rd_idx[1] = AW'(rb);
    #1;
    for (int p = 0; p < 2; p++) begin
      check({req, " tag"}, int'(rd_tag[p]), int'(exp_tag(int'(rd_idx[p]))));
      check({req, " val"}, int'(rd_val[p]), int'(exp_val(int'(rd_idx[p]))));
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; rn_en = 0; rn_idx = 0; rn_tag = 0;
    bus_valid = 0; bus_tag = 0; bus_val = 0; rd_idx = '0;
    for (int i = 0; i < NR; i++) begin mq[i] = 0; mv[i] = IV; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state, literal check
    for (int i = 0; i < NR; i++) begin
      rd_idx[0] = AW'(i); #1;
      check("R1 reset tag", int'(rd_tag[0]), 0);
      check("R1 reset val", int'(rd_val[0]), 5);
      @(negedge clk);
    end

    // R9 lookup during rename sees old state; R11 both ports same reg
    cyc("R9", 1, 3, 6, 0, 0, 0, 3, 3);
    // R2 tag visible, R10 value zero while pending
    cyc("R2", 0, 0, 0, 0, 0, 0, 3, 3);
    check("R10 pending val", int'(rd_val[0]), 0);
    // R3 retag, then stale broadcast of old tag
    cyc("R3", 1, 3, 9, 0, 0, 0, 3, 4);
    cyc("R3", 0, 0, 0, 1, 6, 77, 3, 4);
    cyc("R3", 0, 0, 0, 0, 0, 0, 3, 3);
    check("R3 still newest", int'(rd_tag[0]), 9);
    // R7 rename and matching broadcast same cycle
    cyc("R7", 1, 3, 11, 1, 9, 55, 3, 3);
    cyc("R7", 0, 0, 0, 0, 0, 0, 3, 3);
    check("R7 rename wins", int'(rd_tag[0]), 11);
    // R8 bypass, then R4 writeback
    cyc("R8", 0, 0, 0, 1, 11, 123, 3, 5);
    cyc("R4", 0, 0, 0, 0, 0, 0, 3, 3);
    check("R4 writeback", int'(rd_val[0]), 123);
    // R6 one broadcast updates two registers
    cyc("R6", 1, 1, 4, 0, 0, 0, 1, 2);
    cyc("R6", 1, 2, 4, 0, 0, 0, 1, 2);
    cyc("R6", 0, 0, 0, 1, 4, 900, 1, 2);
    cyc("R6", 0, 0, 0, 0, 0, 0, 1, 2);
    check("R6 both cleared", int'(rd_val[0]) + int'(rd_val[1]), 1800);
    // R5 bus_valid low and tag zero ignored
    cyc("R5", 1, 6, 7, 0, 7, 321, 6, 6);
    cyc("R5", 0, 0, 0, 1, 0, 444, 6, 0);
    cyc("R5", 0, 0, 0, 0, 0, 0, 6, 0);
    check("R5 ignored", int'(rd_tag[0]), 7);

    // random traffic (R2..R11)
    for (int n = 0; n < 4000; n++) begin
      int bt = (($urandom % 10) < 7) ? int'(mq[$urandom % NR]) : int'($urandom % 16);
      cyc("R5 random", ($urandom % 2) == 1, int'($urandom % NR), 1 + int'($urandom % 15),
          ($urandom % 3) != 0, bt, int'($urandom % 65536),
          int'($urandom % NR), int'($urandom % NR));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule